// File: doc/BRIEF.md
# Tick-Count Watchdog Timer

This peripheral guards a system against software that has stopped making progress. Software loads a tick count into a 32-bit down-counter over a simple register bus. The bus has a write strobe, a read strobe, a word address and 32-bit data paths in each direction. From then on, the counter steps down by one on each tick of the selected tick source. If software does not load a fresh count in time, the counter arrives at one and the block raises a system reset request. A counter holding zero is the stopped state. No separate enable bit exists, so the count value alone says whether the watchdog is armed.

A second register controls two things. It chooses which of two tick enables drives the countdown: a crystal-derived tick or an alternate tick. It also carries a disable flag. While the flag is set, the counter is frozen and the reset request is masked. Writing the value one to the counter raises the reset request on the next cycle, which gives software a way to restart the system on purpose.

Top module: `tick_watchdog`

## Requirements
- R1: After the synchronous active-low reset, the counter reads 0, the configuration register reads 0, and `sys_rst_req` is low.
- R2: Word address 0 holds the counter and word address 1 holds the configuration. A read returns data on `bus_rdata` one cycle after `bus_re`. A configuration read shows only bit 0 and bit 31, with all other bits reading 0. Any other address reads 0, and writes to it are ignored.
- R3: When the counter is above 1, the flag is clear and the selected tick is high, the counter drops by exactly one at that clock edge.
- R4: When the counter reaches 1 with the flag clear, `sys_rst_req` goes high. The counter then stays at 1 under further ticks, and the request stays high until the counter is rewritten.
- R5: A counter value of 0, whether from reset or from writing 0, does not change under ticks and never raises `sys_rst_req`.
- R6: Writing 1 to the counter raises `sys_rst_req` in the cycle after the write.
- R7: Configuration bit 0 picks the tick source: 1 selects `xtal_tick` and 0 selects `alt_tick`. Ticks on the source that is not selected have no effect.
- R8: Configuration bit 31 is the disable flag. While it is 1, the counter holds its value and `sys_rst_req` is low. Clearing it lets counting and the request resume.
- R9: A counter write is the refresh. Any written value replaces the count, and a write takes priority over a tick in the same cycle.
- R10: A counter read returns the live count at the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (2) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid one cycle after `bus_re` |
| xtal_tick | input | 1 | Crystal-derived tick enable |
| alt_tick | input | 1 | Alternate tick enable |
| sys_rst_req | output | 1 | System reset request |

## Verification
A write or a selected tick changes the counter at the next clock edge. `sys_rst_req` is decoded from the counter and the disable flag without another register, so it changes in that same cycle. Read data arrives one edge after the strobe. The bench drives every input on the falling edge and samples `sys_rst_req` on the falling edge right after the stimulus edge. Each expected read value goes into a queue when its strobe is driven, and a monitor checks it on the falling edge after the capturing edge.

// File: rtl/tick_watchdog_pkg.sv
// Package: register word indices and configuration bit positions shared by
// the watchdog modules. Assumes a word-addressed register bus.
package tick_watchdog_pkg;
    localparam int unsigned REG_COUNT   = 0;  // live down-counter
    localparam int unsigned REG_CFG     = 1;  // source select and disable
    localparam int unsigned CFG_SRC_BIT = 0;  // 1: crystal tick, 0: alternate
endpackage

// File: rtl/twd_regbank.sv
// Register bank: decodes bus accesses, holds the configuration bits and
// returns registered read data one cycle after the read strobe.
// Assumes the disable flag is the top data bit.
module twd_regbank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    output logic              cnt_wr,
    output logic              cfg_xtal,
    output logic              cfg_dis,
    output logic [DATA_W-1:0] bus_rdata
);
    import tick_watchdog_pkg::*;

    localparam int DIS_BIT = DATA_W - 1;

    logic              cfg_wr;
    logic [DATA_W-1:0] cfg_word;

    // Address decode for the two writable registers.
    always_comb begin
        cnt_wr = bus_we && (bus_addr == ADDR_W'(REG_COUNT));
        cfg_wr = bus_we && (bus_addr == ADDR_W'(REG_CFG));
    end

    // Configuration register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_xtal <= 1'b0;
            cfg_dis  <= 1'b0;
        end else if (cfg_wr) begin
            cfg_xtal <= bus_wdata[CFG_SRC_BIT];
            cfg_dis  <= bus_wdata[DIS_BIT];
        end
    end

    // Configuration readback image: unimplemented bits read zero.
    always_comb begin
        cfg_word              = '0;
        cfg_word[CFG_SRC_BIT] = cfg_xtal;
        cfg_word[DIS_BIT]     = cfg_dis;
    end

    // Registered read data mux, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            if (bus_addr == ADDR_W'(REG_COUNT))
                bus_rdata <= cnt_val;
            else if (bus_addr == ADDR_W'(REG_CFG))
                bus_rdata <= cfg_word;
            else
                bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/twd_tick_sel.sv
// Tick selector: passes the crystal tick or the alternate tick to the
// counter. Assumes both ticks are already synchronous one-cycle enables.
module twd_tick_sel (
    input  logic cfg_xtal,
    input  logic xtal_tick,
    input  logic alt_tick,
    output logic tick
);
    // Source mux.
    always_comb tick = cfg_xtal ? xtal_tick : alt_tick;
endmodule

// File: rtl/twd_counter.sv
// Countdown core: loads on a bus write, steps down on each tick while above
// one, freezes under the disable flag and decodes the reset request.
// Assumes a load outranks a tick in the same cycle.
module twd_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              tick,
    input  logic              hold,
    output logic [DATA_W-1:0] cnt,
    output logic              rst_req
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic can_step;

    // Counting is allowed only above one and while not frozen.
    always_comb can_step = tick && !hold && (cnt > ONE);

    // Counter state: load first, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_wr)
            cnt <= wr_val;
        else if (can_step)
            cnt <= cnt - ONE;
    end

    // Reset request while parked at one and not masked.
    always_comb rst_req = (cnt == ONE) && !hold;
endmodule

// File: rtl/tick_watchdog.sv
// Top: watchdog with a register bank, tick selector and countdown core.
// Assumes a synchronous active-low bus reset and a word-addressed bus.
module tick_watchdog #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xtal_tick,
    input  logic              alt_tick,
    output logic              sys_rst_req
);
    logic              cnt_wr;
    logic              cfg_xtal;
    logic              cfg_dis;
    logic              tick_sel;
    logic [DATA_W-1:0] cnt_q;

    twd_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_q),
        .cnt_wr    (cnt_wr),
        .cfg_xtal  (cfg_xtal),
        .cfg_dis   (cfg_dis),
        .bus_rdata (bus_rdata)
    );

    twd_tick_sel u_sel (
        .cfg_xtal  (cfg_xtal),
        .xtal_tick (xtal_tick),
        .alt_tick  (alt_tick),
        .tick      (tick_sel)
    );

    twd_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_wr  (cnt_wr),
        .wr_val  (bus_wdata),
        .tick    (tick_sel),
        .hold    (cfg_dis),
        .cnt     (cnt_q),
        .rst_req (sys_rst_req)
    );
endmodule

// File: rtl/tick_watchdog_chk.sv
// Checker: temporal properties of the watchdog, bound to the top module.
module tick_watchdog_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] cnt,
    input logic              cfg_dis,
    input logic              tick,
    input logic              sys_rst_req
);
    logic wr_cnt;
    always_comb wr_cnt = bus_we && (bus_addr == '0);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (cnt == '0 && !cfg_dis && !sys_rst_req)); // R1
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_cnt |=> cnt == $past(bus_wdata)); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_cnt && tick && !cfg_dis && cnt > DATA_W'(1)) |=> cnt == $past(cnt) - DATA_W'(1)); // R3
    AST_PARK_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_cnt && cnt == DATA_W'(1)) |=> cnt == DATA_W'(1)); // R4
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_cnt && cnt == '0) |=> (cnt == '0 && !sys_rst_req)); // R5
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_cnt && cfg_dis) |=> $stable(cnt)); // R8
    AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n) cfg_dis |-> !sys_rst_req); // R8
    AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!wr_cnt && !tick) |=> $stable(cnt)); // R7
    AST_FORCE_RST: assert property (@(posedge clk) disable iff (!rst_n) (wr_cnt && bus_wdata == DATA_W'(1) && !cfg_dis && !(bus_we && bus_addr == ADDR_W'(1))) |=> sys_rst_req); // R6
endmodule

bind tick_watchdog tick_watchdog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cnt         (cnt_q),
    .cfg_dis     (cfg_dis),
    .tick        (tick_sel),
    .sys_rst_req (sys_rst_req)
);

// File: tb/tick_watchdog_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module tick_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xtal_tick = 1'b0;
    logic        alt_tick = 1'b0;
    logic        sys_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    tick_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xtal_tick(xtal_tick), .alt_tick(alt_tick), .sys_rst_req(sys_rst_req)
    );

    // Remember which edges captured a read.
    always @(posedge clk) rd_seen <= bus_re && rst_n;

    // Monitor: compare read data one cycle after the strobe.
    always @(negedge clk) begin
        exp_t it;
        if (rd_seen) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL read with empty scoreboard: actual %h expected none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.val) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.val);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        it.val = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic tick_x(input int n);
        @(negedge clk);
        xtal_tick = 1'b1;
        repeat (n) @(negedge clk);
        xtal_tick = 1'b0;
    endtask

    task automatic tick_a(input int n);
        @(negedge clk);
        alt_tick = 1'b1;
        repeat (n) @(negedge clk);
        alt_tick = 1'b0;
    endtask

    task automatic chk_rst(input logic e, input string tag);
        checks++;
        if (sys_rst_req !== e) begin
            errors++;
            $display("FAIL %s: sys_rst_req actual %b expected %b", tag, sys_rst_req, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_rst(1'b0, "R1 request low in reset");
        rst_n = 1'b1;
        chk_rst(1'b0, "R1 request low after reset");
        rd(2'd0, 32'h0, "R1 counter after reset");
        rd(2'd1, 32'h0, "R1 config after reset");

        wr(2'd1, 32'hFFFF_FFFE);
        rd(2'd1, 32'h8000_0000, "R2 config shows bits 31 and 0 only");
        wr(2'd1, 32'h0000_0001);
        rd(2'd1, 32'h0000_0001, "R2 config source bit");
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, 32'h0, "R2 unused address reads zero");
        rd(2'd0, 32'h0, "R2 unused address write ignored");

        wr(2'd0, 32'd10);
        rd(2'd0, 32'd10, "R10 live count after load");
        tick_a(3);
        rd(2'd0, 32'd7, "R3 three alternate ticks");
        tick_x(5);
        rd(2'd0, 32'd7, "R7 crystal ticks ignored when source bit 0");
        wr(2'd1, 32'd1);
        tick_a(4);
        rd(2'd0, 32'd7, "R7 alternate ticks ignored when source bit 1");
        tick_x(2);
        rd(2'd0, 32'd5, "R7 crystal ticks counted");
        chk_rst(1'b0, "R3 no request above one");

        tick_x(4);
        chk_rst(1'b1, "R4 request at one");
        tick_x(3);
        rd(2'd0, 32'd1, "R4 counter parks at one");
        chk_rst(1'b1, "R4 request held");
        wr(2'd0, 32'd20);
        chk_rst(1'b0, "R4 refresh clears request");
        rd(2'd0, 32'd20, "R9 refresh reloads");

        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'd50; xtal_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; xtal_tick = 1'b0;
        rd(2'd0, 32'd50, "R9 write beats tick");
        tick_x(1);
        rd(2'd0, 32'd49, "R3 single tick");

        wr(2'd1, 32'h8000_0001);
        tick_x(5);
        rd(2'd0, 32'd49, "R8 frozen while disabled");
        wr(2'd0, 32'd1);
        chk_rst(1'b0, "R8 request masked at one");
        rd(2'd0, 32'd1, "R8 count one while disabled");
        wr(2'd1, 32'd1);
        chk_rst(1'b1, "R8 request after flag clears");

        wr(2'd0, 32'd0);
        chk_rst(1'b0, "R5 stop clears request");
        tick_x(5);
        rd(2'd0, 32'd0, "R5 zero does not count");
        chk_rst(1'b0, "R5 no request at zero");

        wr(2'd0, 32'd1);
        chk_rst(1'b1, "R6 write of one requests reset");
        wr(2'd0, 32'd3);
        chk_rst(1'b0, "R6 rewrite clears forced request");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2 reads left unchecked: actual %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule